// File: doc/BRIEF.md
# Static RAM with Bulk Clear

This block is a clocked model of a 1024-word by 4-bit static memory with separate 4-bit input and output data paths, a 10-bit address and four active-low controls: chip select, write enable, output enable and clear. Each rising clock edge samples the controls and performs one operation. The operation is one of read, write, whole-array clear or nothing.

The clear does not walk the array. The array is held as 64 rows of 64 bits, with 16 words per row. The upper six address bits pick the row and the lower four pick the word inside it. Each row carries a valid flag, and a clear drops all 64 flags on a single edge. A read from a row whose flag is low returns zero. The first write into such a row stores the new word, zero-fills the other fifteen words and raises the flag. Only a selected device reacts to the clear input, so a board-wide clear line affects only the devices whose chip select is low.

Read data is registered. A drive flag, `dout_en`, stands in for the three-state output. `dout_en` is high only in the cycle after an edge that sampled a valid read condition. At any other time `dout` is held at zero.

Top module: `qram_clr`

## Requirements
- R1: An edge with cs_n=0, we_n=0 and clr_n=1 stores `din` into the word at `addr`, and a later read of that address returns it. Writes to other addresses leave that word unchanged.
- R2: An edge with cs_n=0, oe_n=0, we_n=1 and clr_n=1 puts the word at `addr` on `dout` and raises `dout_en`. Both become visible right after that edge and hold until the next edge.
- R3: After any edge where cs_n=1, oe_n=1, we_n=0 or clr_n=0 was sampled, `dout_en` is 0 and `dout` is 4'h0.
- R4: An edge with cs_n=0 and clr_n=0 clears the whole array. A read sampled on the very next edge, and on any later edge before a new write to that address, returns 4'h0.
- R5: While cs_n=1, the clr_n and we_n inputs have no effect on the array contents.
- R6: When cs_n=0 and clr_n=0 are sampled together with we_n=0, the clear is performed and no write takes place. The addressed word reads 4'h0 afterwards.
- R7: The 16 addresses sharing `addr[9:4]` form one row, and `addr[3:0]` selects the word within it. After a clear, writing one word of a row leaves the other fifteen words of that row, and all other rows, reading 4'h0.
- R8: An edge with rst_n=0 leaves `dout_en`=0 and `dout`=4'h0. After reset every address reads 4'h0 until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every operation is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of flags and output register |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| clr_n | input | 1 | Active-low whole-array clear request |
| addr | input | 10 | Word address: [9:4] row, [3:0] word in row |
| din | input | 4 | Write data |
| dout | output | 4 | Registered read data, zero when not driven |
| dout_en | output | 1 | High when `dout` models a driven output |

## Verification
A wrong row flag shows up on the first read of any of the 16 words in that row. A stale flag lets old data reappear after a clear, and a flag that fails to rise turns freshly written data into zero; either is visible one cycle after the read is sampled. A write that merges wrongly into an invalid row leaks old words into neighbours that should read zero. Full-array sweeps after each write pass, clear and deselect phase, plus a word-by-word sweep of a partly written row, expose every such fault within one read.

// File: rtl/qram_pkg.sv
// Package: shared sizes and the operation code used inside the memory.
// Assumes: one operation per clock edge; the default sizes give 1024 x 4.
package qram_pkg;

    localparam int unsigned QR_ADDR_W   = 10;
    localparam int unsigned QR_DATA_W   = 4;
    localparam int unsigned QR_ROW_BITS = 6;

    // Operation selected for the current edge, in priority-resolved form.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_CLEAR = 2'd3
    } qram_op_e;

endpackage

// File: rtl/qram_cmd_decode.sv
// Module: turns the four active-low controls into one operation.
// Assumes: a deselected device does nothing. Clear outranks write, and
// write outranks read.
module qram_cmd_decode
    import qram_pkg::*;
(
    input  logic     cs_n,
    input  logic     we_n,
    input  logic     oe_n,
    input  logic     clr_n,
    output qram_op_e op
);

    // Priority decode of the sampled controls.
    always_comb begin
        if (cs_n)       op = OP_IDLE;
        else if (!clr_n) op = OP_CLEAR;
        else if (!we_n)  op = OP_WRITE;
        else if (!oe_n)  op = OP_READ;
        else             op = OP_IDLE;
    end

endmodule

// File: rtl/qram_row_valid.sv
// Module: one valid flag per row. A clear drops every flag on one edge,
// and a write raises the flag of its row.
// Assumes: clear and write are never requested on the same edge.
module qram_row_valid #(
    parameter int unsigned ROW_BITS = 6,
    localparam int unsigned ROWS    = 2 ** ROW_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_go,
    input  logic                wr_go,
    input  logic [ROW_BITS-1:0] wr_row,
    input  logic [ROW_BITS-1:0] rd_row,
    output logic                wr_valid,
    output logic                rd_valid
);

    logic [ROWS-1:0] valid_q;

    // Flag update: reset and clear drop all flags, a write sets its row's flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clr_go) begin
            valid_q <= '0;
        end else if (wr_go) begin
            valid_q[wr_row] <= 1'b1;
        end
    end

    // Flag lookup for the write merge and for read masking.
    always_comb begin
        wr_valid = valid_q[wr_row];
        rd_valid = valid_q[rd_row];
    end

    // R4: a clear leaves no row flagged valid.
    assert_clear_drops_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_go |=> (valid_q == '0));

    // R7: a written row is flagged valid after the write edge.
    assert_write_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> valid_q[$past(wr_row)]);

    // R5: without clear or write, the flags do not move.
    assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_go && !wr_go) |=> $stable(valid_q));

    // R6: decode never asks for clear and write together.
    assert_clear_excludes_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_go && wr_go));

endmodule

// File: rtl/qram_row_store.sv
// Module: row-wide storage of the data words. A write rewrites its whole row.
// If the row is flagged invalid, the other words are zero-filled; otherwise
// they are kept.
// Assumes: the valid flag of the write row is supplied by the flag block.
// The storage itself is not reset.
module qram_row_store #(
    parameter int unsigned ROW_BITS = 6,
    parameter int unsigned COL_BITS = 4,
    parameter int unsigned DATA_W   = 4,
    localparam int unsigned ROWS    = 2 ** ROW_BITS,
    localparam int unsigned WPR     = 2 ** COL_BITS,
    localparam int unsigned ROW_W   = WPR * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_go,
    input  logic                wr_valid,
    input  logic [ROW_BITS-1:0] wr_row,
    input  logic [COL_BITS-1:0] wr_col,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ROW_BITS-1:0] rd_row,
    input  logic [COL_BITS-1:0] rd_col,
    output logic [DATA_W-1:0]   rd_word
);

    logic [ROW_W-1:0] rows_q [ROWS];
    logic [ROW_W-1:0] old_row;
    logic [ROW_W-1:0] new_row;

    // Current contents of the row being written.
    always_comb old_row = rows_q[wr_row];

    // Per-word merge: new word at its column; others kept or zero-filled.
    for (genvar c = 0; c < WPR; c++) begin : g_merge
        always_comb begin
            if (wr_col == COL_BITS'(c))
                new_row[c*DATA_W +: DATA_W] = wr_data;
            else if (wr_valid)
                new_row[c*DATA_W +: DATA_W] = old_row[c*DATA_W +: DATA_W];
            else
                new_row[c*DATA_W +: DATA_W] = '0;
        end
    end

    // Row write on a write edge.
    always_ff @(posedge clk) begin
        if (wr_go) begin
            rows_q[wr_row] <= new_row;
        end
    end

    // Word select for the read path.
    always_comb rd_word = rows_q[rd_row][int'(rd_col)*DATA_W +: DATA_W];

    // R1: the written word is present in its row after the write edge.
    assert_word_stored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (rows_q[$past(wr_row)][int'($past(wr_col))*DATA_W +: DATA_W]
                   == $past(wr_data)));

endmodule

// File: rtl/qram_out_reg.sv
// Module: registered read data and drive flag. Data is masked to zero
// when the row is invalid or no read was sampled.
// Assumes: rd_go is high only for a selected, enabled, non-write,
// non-clear edge.
module qram_out_reg #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    // Output register: drive flag follows the read, data masked by row flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout_en <= rd_go;
            dout    <= (rd_go && rd_valid) ? rd_word : '0;
        end
    end

    // R3: an undriven output always carries zero.
    assert_idle_output_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

    // R4: a read of an invalid row returns zero.
    assert_invalid_row_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !rd_valid) |=> (dout == '0));

endmodule

// File: rtl/qram_clr.sv
// Module: top of the 1024 x 4 memory with whole-array clear. It decodes
// the controls, keeps row flags and row storage, and registers the output.
// Assumes: every control is sampled on the rising clock edge.
// rst_n is a synchronous active-low reset.
module qram_clr
    import qram_pkg::*;
#(
    parameter int unsigned ADDR_W   = QR_ADDR_W,
    parameter int unsigned DATA_W   = QR_DATA_W,
    parameter int unsigned ROW_BITS = QR_ROW_BITS,
    localparam int unsigned COL_BITS = ADDR_W - ROW_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    qram_op_e            op;
    logic                rd_go;
    logic                wr_go;
    logic                clr_go;
    logic [ROW_BITS-1:0] row;
    logic [COL_BITS-1:0] col;
    logic                wr_valid;
    logic                rd_valid;
    logic [DATA_W-1:0]   rd_word;

    qram_cmd_decode u_decode (
        .cs_n  (cs_n),
        .we_n  (we_n),
        .oe_n  (oe_n),
        .clr_n (clr_n),
        .op    (op)
    );

    // Split the operation into strobes and the address into row and column.
    always_comb begin
        rd_go  = (op == OP_READ);
        wr_go  = (op == OP_WRITE);
        clr_go = (op == OP_CLEAR);
        row    = addr[ADDR_W-1:COL_BITS];
        col    = addr[COL_BITS-1:0];
    end

    qram_row_valid #(
        .ROW_BITS (ROW_BITS)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_go   (clr_go),
        .wr_go    (wr_go),
        .wr_row   (row),
        .rd_row   (row),
        .wr_valid (wr_valid),
        .rd_valid (rd_valid)
    );

    qram_row_store #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (wr_go),
        .wr_valid (wr_valid),
        .wr_row   (row),
        .wr_col   (col),
        .wr_data  (din),
        .rd_row   (row),
        .rd_col   (col),
        .rd_word  (rd_word)
    );

    qram_out_reg #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_go    (rd_go),
        .rd_valid (rd_valid),
        .rd_word  (rd_word),
        .dout     (dout),
        .dout_en  (dout_en)
    );

    // R2: a sampled read condition drives the output on the next cycle.
    assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !oe_n && we_n && clr_n) |=> dout_en);

    // R3: deselect, output disable, write or clear leave the output undriven.
    assert_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || oe_n || !we_n || !clr_n) |=> !dout_en);

    // R4: a read right after a clear returns zero.
    assert_read_after_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cs_n && !clr_n) && !cs_n && !oe_n && we_n && clr_n) |=> (dout == '0));

    // R8: a reset edge leaves the output undriven and zero.
    assert_reset_output_R8: assert property (@(posedge clk)
        !rst_n |=> (!dout_en && dout == '0));

endmodule

// File: tb/qram_clr_tb_top.sv
// Bench: full-address sweeps against a word model computed in the bench.
module qram_clr_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n, we_n, oe_n, clr_n;
    logic [9:0] addr;
    logic [3:0] din;
    logic [3:0] dout;
    logic       dout_en;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [3:0] exp_mem [1024];

    always #5 clk = ~clk;

    qram_clr dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .clr_n   (clr_n),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en)
    );

    function automatic logic [3:0] pat(input int a, input int seed);
        return 4'((a * 5 + (a >> 4) * 3 + seed) % 16);
    endfunction

    task automatic model_zero();
        for (int i = 0; i < 1024; i++) exp_mem[i] = 4'h0;
    endtask

    // One clock: drive at the falling edge, update the model, land on the next falling edge.
    task automatic step(input logic cs, input logic we, input logic oe, input logic cl,
                        input int a, input logic [3:0] d);
        cs_n = cs; we_n = we; oe_n = oe; clr_n = cl;
        addr = 10'(a); din = d;
        if (!rst_n)            model_zero();
        else if (!cs && !cl)   model_zero();
        else if (!cs && !we)   exp_mem[a] = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_out(input string req, input int a,
                             input logic en_exp, input logic [3:0] d_exp);
        checks++;
        if (dout_en !== en_exp || dout !== d_exp) begin
            failures++;
            $display("FAIL %s addr=%0d actual en=%b dout=%h expected en=%b dout=%h",
                     req, a, dout_en, dout, en_exp, d_exp);
        end
    endtask

    task automatic rd(input int a, input string req);
        step(1'b0, 1'b1, 1'b0, 1'b1, a, 4'h0);
        check_out(req, a, 1'b1, exp_mem[a]);
    endtask

    task automatic rd_all(input string req);
        for (int a = 0; a < 1024; a++) rd(a, req);
    endtask

    task automatic wr_all(input int seed);
        for (int a = 0; a < 1024; a++) step(1'b0, 1'b0, 1'b1, 1'b1, a, pat(a, seed));
    endtask

    initial begin
        rst_n = 1'b0;
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; clr_n = 1'b1;
        addr = '0; din = '0;
        model_zero();
        repeat (3) @(negedge clk);
        check_out("R8 reset", 0, 1'b0, 4'h0);
        rst_n = 1'b1;

        // R8: unwritten memory reads zero after reset.
        rd(0, "R8 post-reset");
        rd(1023, "R8 post-reset");
        rd(500, "R8 post-reset");

        // R1/R2: write every word, with the output undriven during writes (R3).
        step(1'b0, 1'b0, 1'b1, 1'b1, 17, 4'hA);
        check_out("R3 write", 17, 1'b0, 4'h0);
        wr_all(1);
        rd_all("R1 R2 sweep");

        // R5: deselected write and clear have no effect; R3: no drive.
        step(1'b1, 1'b0, 1'b1, 1'b1, 7, ~exp_mem[7]);
        check_out("R3 deselect write", 7, 1'b0, 4'h0);
        step(1'b1, 1'b1, 1'b0, 1'b1, 7, 4'h0);
        check_out("R3 deselect read", 7, 1'b0, 4'h0);
        step(1'b1, 1'b1, 1'b1, 1'b0, 7, 4'h0);
        check_out("R3 deselect clear", 7, 1'b0, 4'h0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 300, 4'h5);
        rd_all("R5 deselect sweep");

        // R3: output disabled.
        step(1'b0, 1'b1, 1'b1, 1'b1, 9, 4'h0);
        check_out("R3 oe high", 9, 1'b0, 4'h0);

        // R4: clear with oe low gives no drive; next-edge read is zero.
        step(1'b0, 1'b1, 1'b0, 1'b0, 40, 4'h0);
        check_out("R3 clear", 40, 1'b0, 4'h0);
        rd(40, "R4 immediate");
        rd_all("R4 cleared sweep");

        // R6: clear together with write performs no write.
        wr_all(2);
        step(1'b0, 1'b0, 1'b1, 1'b0, 33, 4'hF);
        rd(33, "R6 priority");
        rd(34, "R6 priority");

        // R7: single writes into a cleared row leave neighbours zero.
        step(1'b0, 1'b0, 1'b1, 1'b1, 'h25, 4'h9);
        step(1'b0, 1'b0, 1'b1, 1'b1, 'h2A, 4'h6);
        for (int a = 'h20; a < 'h30; a++) rd(a, "R7 row fill");
        for (int a = 'h30; a < 'h40; a++) rd(a, "R7 other row");
        rd_all("R7 sweep");

        // R1: repopulate after clear and merge into valid rows.
        wr_all(3);
        step(1'b0, 1'b0, 1'b1, 1'b1, 'h25, 4'h1);
        rd_all("R1 refill");

        // R8: reset mid-run while a read is requested.
        rst_n = 1'b0;
        step(1'b0, 1'b1, 1'b0, 1'b1, 5, 4'h0);
        check_out("R8 mid reset", 5, 1'b0, 4'h0);
        rst_n = 1'b1;
        rd(5, "R8 after reset");
        rd(1000, "R8 after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule